// File: doc/BRIEF.md
# Complementary PWM Dead-Time Generator

This block turns a single PWM waveform into a pair of complementary drive signals for two external power switches: a primary output that follows the waveform and a secondary output that follows its inverse. Each time the source waveform changes level, both outputs are held low for a programmable guard interval. The switch that is turning off drops at once. The switch that is turning on waits until the interval has run out. As a result, the two switches are never conducting together.

The guard interval is set by a 12-bit count. It is timed either in PWM clock cycles or in ticks of an external prescaler strobe. The enable, the count and the timing source sit in one control register. That register accepts writes only after a three-byte unlock sequence has been written to a separate key register, and writing a zero key locks it again. New count and timing-source values are captured at the next source edge, so a blanking interval that is already running always completes as it started.

Top module: `cpwm_deadtime`

## Requirements
- R1: During reset and after it, the control register reads zero, writes are locked, the guard is disabled, and both outputs are low while reset is held.
- R2: A control write (wr_sel=0) changes the register only while unlocked. Readback shows the count in bits [11:0], the guard enable in bit 16 and the timing source in bit 24, and every other bit reads 0.
- R3: Key writes (wr_sel=1, value in wr_data[7:0]) of 0x59, 0x16 and 0x88 in consecutive key writes unlock the register. A wrong value restarts the sequence, and a 0x59 in that position counts as the first byte.
- R4: A key write of 0x00 locks the register again immediately.
- R5: With the guard disabled, out_pri equals the source and out_cmp its inverse, one clock after the source changes.
- R6: On a rising source edge with the guard enabled, out_cmp goes low on the first clock. out_pri stays low for count+1 clocks and then goes high.
- R7: On a falling source edge with the guard enabled, out_pri goes low on the first clock. out_cmp stays low for count+1 clocks and then goes high.
- R8: out_pri and out_cmp are never high in the same cycle.
- R9: With the timing source bit at 1, the interval lasts count+1 presc_tick pulses, which is (count+1)·P clocks for a strobe every P clocks.
- R10: A source edge that arrives during an interval restarts it. Both outputs stay low until a full interval has passed since the latest edge.
- R11: A count written during an interval does not change that interval. It applies from the next source edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the control register, 1 the key register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Control register readback |
| presc_tick | input | 1 | One-clock strobe from the prescaler |
| src_in | input | 1 | Source PWM waveform |
| out_pri | output | 1 | Primary drive output |
| out_cmp | output | 1 | Complementary drive output |

## Verification
The guard is measured on rising and falling edges for counts of 0, 1, 7, 300 and 4095, timed by the clock. A count of 0 shows whether the interval is one tick or zero, and 4095 shows the full field width. Two counts timed by prescaler strobes of period 3 and 4 show whether the counter advances on strobes or on clocks. Key sequences with a wrong middle byte, with a repeated first byte, and followed by a zero key show that the lock restarts and re-engages correctly. An edge that arrives during an interval, and a count rewritten during an interval, show that the counter reloads from the latest edge and that captured settings are held.

// File: rtl/cpwm_dt_pkg.sv
package cpwm_dt_pkg;
  localparam int DT_CNT_W   = 12;
  localparam int DT_DATA_W  = 32;
  localparam int DT_EN_POS  = 16;
  localparam int DT_SEL_POS = 24;
  localparam int DT_KEY_W   = 8;

  localparam logic [DT_KEY_W-1:0] KEY_FIRST  = 8'h59;
  localparam logic [DT_KEY_W-1:0] KEY_SECOND = 8'h16;
  localparam logic [DT_KEY_W-1:0] KEY_THIRD  = 8'h88;
  localparam logic [DT_KEY_W-1:0] KEY_RELOCK = 8'h00;

  typedef enum logic [1:0] {LK_IDLE, LK_GOT1, LK_GOT2, LK_OPEN} lock_st_e;

  // Next unlock state after one key write.
  function automatic lock_st_e key_next(lock_st_e st, logic [DT_KEY_W-1:0] key);
    lock_st_e nx;
    if (key == KEY_RELOCK) begin
      nx = LK_IDLE;
    end else begin
      case (st)
        LK_IDLE: nx = (key == KEY_FIRST)  ? LK_GOT1 : LK_IDLE;
        LK_GOT1: nx = (key == KEY_SECOND) ? LK_GOT2 :
                      (key == KEY_FIRST)  ? LK_GOT1 : LK_IDLE;
        LK_GOT2: nx = (key == KEY_THIRD)  ? LK_OPEN :
                      (key == KEY_FIRST)  ? LK_GOT1 : LK_IDLE;
        default: nx = LK_OPEN;
      endcase
    end
    return nx;
  endfunction

  // Interval ends on a counted tick once the counter has reached zero.
  function automatic logic dt_expire(logic busy, logic tick, logic [DT_CNT_W-1:0] cnt);
    return busy && tick && (cnt == '0);
  endfunction

  // Length of one guard interval in PWM clocks for a strobe period.
  function automatic int unsigned blank_clocks(int unsigned cnt, int unsigned period);
    return (cnt + 1) * period;
  endfunction
endpackage

// File: rtl/cpwm_dt_lock.sv
module cpwm_dt_lock
  import cpwm_dt_pkg::*;
#(
  parameter int DATA_W  = DT_DATA_W,
  parameter int CNT_W   = DT_CNT_W,
  parameter int EN_POS  = DT_EN_POS,
  parameter int SEL_POS = DT_SEL_POS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              cfg_en,
  output logic              cfg_sel,
  output logic [CNT_W-1:0]  cfg_cnt,
  output logic              unlocked
);
  lock_st_e st_q;
  logic     key_wr;
  logic     ctrl_wr;

  assign key_wr   = wr_en && wr_sel;
  assign ctrl_wr  = wr_en && !wr_sel && (st_q == LK_OPEN);
  assign unlocked = (st_q == LK_OPEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= LK_IDLE;
      cfg_en  <= 1'b0;
      cfg_sel <= 1'b0;
      cfg_cnt <= '0;
    end else begin
      if (key_wr) st_q <= key_next(st_q, wr_data[DT_KEY_W-1:0]);
      if (ctrl_wr) begin
        cfg_cnt <= wr_data[CNT_W-1:0];
        cfg_en  <= wr_data[EN_POS];
        cfg_sel <= wr_data[SEL_POS];
      end
    end
  end

  always_comb begin
    rd_data              = '0;
    rd_data[CNT_W-1:0]   = cfg_cnt;
    rd_data[EN_POS]      = cfg_en;
    rd_data[SEL_POS]     = cfg_sel;
  end
endmodule

// File: rtl/cpwm_dt_tick.sv
module cpwm_dt_tick #(
  parameter bit HAS_PRESC = 1'b1
) (
  input  logic sel,
  input  logic presc_tick,
  output logic tick
);
  generate
    if (HAS_PRESC) begin : g_presc
      assign tick = sel ? presc_tick : 1'b1;
    end else begin : g_raw
      logic unused_in;
      assign unused_in = sel ^ presc_tick;
      assign tick      = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/cpwm_dt_core.sv
module cpwm_dt_core
  import cpwm_dt_pkg::*;
#(
  parameter int CNT_W     = DT_CNT_W,
  parameter bit HAS_PRESC = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_in,
  input  logic             presc_tick,
  input  logic             cfg_en,
  input  logic             cfg_sel,
  input  logic [CNT_W-1:0] cfg_cnt,
  output logic             out_pri,
  output logic             out_cmp,
  output logic             edge_evt,
  output logic             busy,
  output logic             expire
);
  logic             src_q;
  logic             live;
  logic             act_sel;
  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  cpwm_dt_tick #(.HAS_PRESC(HAS_PRESC)) u_tick (
    .sel        (act_sel),
    .presc_tick (presc_tick),
    .tick       (tick)
  );

  assign edge_evt = live && (src_in != src_q);
  assign expire   = dt_expire(busy, tick, cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= 1'b0;
      live    <= 1'b0;
      busy    <= 1'b0;
      act_sel <= 1'b0;
      cnt_q   <= '0;
    end else begin
      live  <= 1'b1;
      src_q <= src_in;
      if (edge_evt) begin
        act_sel <= cfg_sel;
        cnt_q   <= cfg_cnt;
        busy    <= cfg_en;
      end else if (!cfg_en) begin
        busy <= 1'b0;
      end else if (expire) begin
        busy <= 1'b0;
      end else if (busy && tick) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign out_pri = live && src_q && !busy;
  assign out_cmp = live && !src_q && !busy;
endmodule

// File: rtl/cpwm_deadtime.sv
module cpwm_deadtime
  import cpwm_dt_pkg::*;
#(
  parameter int DATA_W    = DT_DATA_W,
  parameter int CNT_W     = DT_CNT_W,
  parameter int EN_POS    = DT_EN_POS,
  parameter int SEL_POS   = DT_SEL_POS,
  parameter bit HAS_PRESC = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              presc_tick,
  input  logic              src_in,
  output logic              out_pri,
  output logic              out_cmp
);
  logic             cfg_en;
  logic             cfg_sel;
  logic [CNT_W-1:0] cfg_cnt;
  logic             unlocked;
  logic             edge_evt;
  logic             busy;
  logic             expire;

  cpwm_dt_lock #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .EN_POS(EN_POS), .SEL_POS(SEL_POS)
  ) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .cfg_en   (cfg_en),
    .cfg_sel  (cfg_sel),
    .cfg_cnt  (cfg_cnt),
    .unlocked (unlocked)
  );

  cpwm_dt_core #(.CNT_W(CNT_W), .HAS_PRESC(HAS_PRESC)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_in     (src_in),
    .presc_tick (presc_tick),
    .cfg_en     (cfg_en),
    .cfg_sel    (cfg_sel),
    .cfg_cnt    (cfg_cnt),
    .out_pri    (out_pri),
    .out_cmp    (out_cmp),
    .edge_evt   (edge_evt),
    .busy       (busy),
    .expire     (expire)
  );
endmodule

// File: rtl/cpwm_deadtime_chk.sv
module cpwm_deadtime_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              out_pri,
  input logic              out_cmp,
  input logic              edge_evt,
  input logic              cfg_en,
  input logic              unlocked
);
  AST_PAIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_pri && out_cmp)); // R8

  AST_LOCKED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && !unlocked) |=> $stable(rd_data)); // R2

  AST_ZERO_KEY_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && (wr_data[7:0] == 8'h00)) |=> !unlocked); // R4

  AST_EDGE_BLANKS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_evt && cfg_en && !(wr_en && !wr_sel)) |=> (!out_pri && !out_cmp)); // R6

  AST_PLAIN_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && $past(!cfg_en) && $past(rst_n)) |-> (out_pri != out_cmp)); // R5
endmodule

bind cpwm_deadtime cpwm_deadtime_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_sel   (wr_sel),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .out_pri  (out_pri),
  .out_cmp  (out_cmp),
  .edge_evt (edge_evt),
  .cfg_en   (cfg_en),
  .unlocked (unlocked)
);

// File: tb/cpwm_deadtime_test.sv
module cpwm_deadtime_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        presc_tick = 1'b0;
  logic        src_in = 1'b0;
  logic        out_pri;
  logic        out_cmp;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cpwm_deadtime uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_data(rd_data), .presc_tick(presc_tick), .src_in(src_in),
    .out_pri(out_pri), .out_cmp(out_cmp)
  );

  // count, strobe period (1 = clock timed)
  localparam int NVEC = 7;
  localparam int VEC [NVEC][2] = '{
    '{0, 1}, '{1, 1}, '{7, 1}, '{300, 1}, '{4095, 1}, '{2, 3}, '{4, 4}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic unlock();
    wr(1'b1, 32'h59); wr(1'b1, 32'h16); wr(1'b1, 32'h88);
  endtask

  // Drive a source level, then count low samples of the output switching on.
  // stop > 0 returns after that many low samples.
  task automatic blank(input bit val, input int per, input int stop,
                       input string req, output int n);
    int ph;
    logic on_o, off_o;
    @(negedge clk);
    src_in = val; presc_tick = 1'b0; ph = 0; n = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      on_o  = val ? out_pri : out_cmp;
      off_o = val ? out_cmp : out_pri;
      if (off_o) begin
        errors++; checks++;
        $display("FAIL %s R8 off output high actual=1 expected=0", req);
      end
      if (on_o) break;
      n++;
      if (stop > 0 && n == stop) break;
      ph++;
      presc_tick = ((ph % per) == 0);
    end
    presc_tick = 1'b0;
  endtask

  initial begin
    int n;
    int exp;
    #1;
    // R1: reset state
    repeat (2) @(negedge clk);
    check("R1 rd_data", int'(rd_data), 0);
    check("R1 outputs", int'({out_pri, out_cmp}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1/R2: locked after reset, write ignored
    wr(1'b0, 32'h0001_0005);
    check("R2 locked write", int'(rd_data), 0);

    // R5: disabled guard is a plain pair
    @(negedge clk); src_in = 1'b1;
    @(negedge clk);
    check("R5 rise pair", int'({out_pri, out_cmp}), 2);
    @(negedge clk); src_in = 1'b0;
    @(negedge clk);
    check("R5 fall pair", int'({out_pri, out_cmp}), 1);

    // R3: unlock, field masking
    unlock();
    wr(1'b0, 32'hFFFF_FFFF);
    check("R3 R2 masked readback", int'(rd_data), 32'h0101_0FFF);

    // R4: zero key relocks
    wr(1'b1, 32'h00);
    wr(1'b0, 32'h0000_0003);
    check("R4 relocked", int'(rd_data), 32'h0101_0FFF);

    // R3: wrong middle byte restarts
    wr(1'b1, 32'h59); wr(1'b1, 32'h16); wr(1'b1, 32'h33); wr(1'b1, 32'h88);
    wr(1'b0, 32'h0000_0003);
    check("R3 wrong key", int'(rd_data), 32'h0101_0FFF);
    // R3: repeated first byte counts as first
    wr(1'b1, 32'h59); wr(1'b1, 32'h59); wr(1'b1, 32'h16); wr(1'b1, 32'h88);
    wr(1'b0, 32'h0000_0003);
    check("R3 repeated first", int'(rd_data), 3);

    // Vector walk: R6, R7, R9
    for (int v = 0; v < NVEC; v++) begin
      wr(1'b0, 32'h0001_0000 | (VEC[v][1] > 1 ? 32'h0100_0000 : 32'h0) | VEC[v][0]);
      exp = VEC[v][0] + 1;
      exp = exp * VEC[v][1];
      blank(1'b1, VEC[v][1], 0, "R6", n);
      check(VEC[v][1] > 1 ? "R9 rise" : "R6 rise", n, exp);
      blank(1'b0, VEC[v][1], 0, "R7", n);
      check(VEC[v][1] > 1 ? "R9 fall" : "R7 fall", n, exp);
    end

    // R10: retrigger during interval
    wr(1'b0, 32'h0001_0005);
    blank(1'b1, 1, 3, "R10", n);
    check("R10 first part", n, 3);
    blank(1'b0, 1, 0, "R10", n);
    check("R10 restart", n, 6);

    // R11: count rewritten mid-interval
    wr(1'b0, 32'h0001_000A);
    @(negedge clk); src_in = 1'b1;
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'h0001_0002;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    n = 2;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (out_pri) break;
      n++;
    end
    check("R11 held count", n, 11);
    blank(1'b0, 1, 0, "R11", n);
    check("R11 new count", n, 3);

    // R1: reset again clears the register
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clear", int'(rd_data), 0);
    check("R1 reset outputs", int'({out_pri, out_cmp}), 0);
    rst_n = 1'b1;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule